// File: doc/BRIEF.md
# Corrected Error Record Counter

This block keeps the log for corrected errors coming from one error-detection source. Each reported event carries a syndrome. The block holds the most relevant syndrome, a valid bit, a sticky overflow flag and a corrected-error counter that is 8 or 16 bits wide, or is absent. An optional repeat mode splits the count into two counters of equal width. One counts errors whose syndrome equals the held one. The other counts every other error.

Elaboration parameters fix three things: the syndrome overwrite policy, the counter width and the repeat option. A read-only feature word reports that choice to software. A small register port lets software read status, syndrome and counters, preset the counters to a threshold, and clear the valid and overflow bits. When an error event and a software write arrive in the same cycle, the error takes precedence.

Top module: `cer_record`

## Requirements
- R1: After reset, valid, overflow, the held syndrome and all counters read as zero.
- R2: Register address 0 is the read-only feature word. Bits [14:12] hold the counter code: 3'b000 none, 3'b010 8-bit, 3'b100 16-bit. Bit 15 is the repeat flag. Bits [19:18] hold the policy, 2'b00 or 2'b01. All other bits are zero. Address 1 is status, address 2 is the syndrome and address 3 is the counters.
- R3: An error that arrives while valid is clear captures its syndrome and sets valid. It is counted in the single counter, or in repeat mode in the other counter.
- R4: Under policy 0, an error that arrives while valid is set is counted and leaves the held syndrome unchanged.
- R5: Under policy 0 with no counter, an error that arrives while valid is set sets the overflow flag.
- R6: Under policy 1, an error that arrives while valid is set is counted. It replaces the held syndrome unless overflow was already set before that error, in which case the old syndrome is kept.
- R7: A counter increment from all ones to zero sets overflow on the same clock edge as the increment.
- R8: In repeat mode, an error whose syndrome matches the held syndrome (with valid set) increments the repeat counter at bits [32+W-1:32] of address 3. Any other error increments the other counter at bits [32+2W-1:32+W]. Without repeat mode, the single counter sits at bits [32+W-1:32].
- R9: Status (address 1) has valid at bit 0 and overflow at bit 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: A write to address 3 presets the counter fields from the same bit positions.
- R11: A software write in the same cycle as an error event is dropped in full.
- R12: Overflow is sticky. Only a software clear resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | A corrected error is reported this cycle |
| err_syndrome | input | SYN_W | Syndrome of the reported error |
| reg_addr | input | 2 | Register select for read and write |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |

## Verification
The assertions check the following on every cycle:
- capture of the first syndrome;
- keeping or replacing the syndrome under each policy;
- overflow being set after a counter wrap;
- the stickiness of overflow;
- an error event overriding a same-cycle status clear.

The bench covers what the assertions cannot see. It checks the exact counter values and their bit positions, and which counter of the repeat pair moved. It also checks the feature word encoding and the preset path. It does this by sweeping long error sequences, with interleaved clears and presets, through three configurations and comparing against an arithmetic model.

// File: rtl/cer_pkg.sv
package cer_pkg;

  typedef enum logic [1:0] {
    RA_FEAT = 2'd0,
    RA_STAT = 2'd1,
    RA_SYND = 2'd2,
    RA_CNT  = 2'd3
  } reg_addr_e;

  localparam int CNT_LSB    = 32;
  localparam int FW_CNT_LSB = 12;
  localparam int FW_REP_BIT = 15;
  localparam int FW_POL_LSB = 18;
  localparam int ST_VALID   = 0;
  localparam int ST_OVF     = 1;

  typedef struct packed {
    logic count;
    logic capture;
    logic set_of;
    logic to_repeat;
  } cer_action_t;

  function automatic int cnt_width(input int sel);
    case (sel)
      1:       return 8;
      2:       return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] cnt_code(input int sel);
    case (sel)
      1:       return 3'b010;
      2:       return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [63:0] feature_word(input int sel, input int pol, input bit rep);
    logic [63:0] f;
    f = '0;
    f[FW_CNT_LSB +: 3] = cnt_code(sel);
    f[FW_REP_BIT]      = rep;
    f[FW_POL_LSB +: 2] = pol[1:0];
    return f;
  endfunction

endpackage

// File: rtl/cer_counter.sv
module cer_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         wrap
);

  // Increment has priority over a preset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (inc)  value <= value + W'(1);
    else if (load) value <= load_val;
  end

  // All ones going to zero on this edge.
  assign wrap = inc & (&value);

endmodule

// File: rtl/cer_policy.sv
module cer_policy #(
  parameter int POLICY  = 0,
  parameter bit HAS_CNT = 1'b1,
  parameter bit REPEAT  = 1'b0
) (
  input  logic                 ev,
  input  logic                 valid,
  input  logic                 of,
  input  logic                 match,
  output cer_pkg::cer_action_t act
);

  always_comb begin
    act = '0;
    if (ev) begin
      act.count = HAS_CNT;
      if (!valid) begin
        act.capture = 1'b1;
      end else begin
        act.to_repeat = REPEAT & match;
        if (POLICY == 1) act.capture = ~of;
        if (POLICY == 0 && !HAS_CNT) act.set_of = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cer_record.sv
module cer_record import cer_pkg::*; #(
  parameter int SYN_W     = 32,
  parameter int CNT_SEL   = 1,
  parameter int POLICY    = 0,
  parameter bit REPEAT_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [SYN_W-1:0] err_syndrome,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata
);

  localparam int          CW      = cnt_width(CNT_SEL);
  localparam bit          HAS_CNT = (CW > 0);
  localparam bit          REP     = REPEAT_EN && HAS_CNT;
  localparam int          CWS     = HAS_CNT ? CW : 1;
  localparam logic [63:0] FEAT    = feature_word(CNT_SEL, POLICY, REP);

  logic             valid_q, of_q;
  logic [SYN_W-1:0] syn_q;

  // Named events for the checker.
  logic        sw_ok, sw_clr_of, sw_clr_valid, sw_load;
  logic        match, ev_wrap, ev_capture;
  cer_action_t act;

  logic [CWS-1:0] pri_val, sec_val;
  logic           pri_wrap, sec_wrap;
  logic           unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // Error update wins over a same-cycle write.
  assign sw_ok        = reg_we & ~err_valid;
  assign sw_clr_of    = sw_ok & (reg_addr == RA_STAT) & reg_wdata[ST_OVF];
  assign sw_clr_valid = sw_ok & (reg_addr == RA_STAT) & reg_wdata[ST_VALID];
  assign sw_load      = sw_ok & (reg_addr == RA_CNT);

  assign match = (syn_q == err_syndrome);

  cer_policy #(.POLICY(POLICY), .HAS_CNT(HAS_CNT), .REPEAT(REP)) u_pol (
    .ev    (err_valid),
    .valid (valid_q),
    .of    (of_q),
    .match (match),
    .act   (act)
  );

  assign ev_capture = act.capture;

  generate
    if (HAS_CNT) begin : g_pri
      cer_counter #(.W(CW)) u_pri (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (act.count & (REP ? act.to_repeat : 1'b1)),
        .load     (sw_load),
        .load_val (reg_wdata[CNT_LSB +: CW]),
        .value    (pri_val),
        .wrap     (pri_wrap)
      );
    end else begin : g_no_pri
      assign pri_val  = '0;
      assign pri_wrap = 1'b0;
    end

    if (REP) begin : g_sec
      cer_counter #(.W(CW)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (act.count & ~act.to_repeat),
        .load     (sw_load),
        .load_val (reg_wdata[CNT_LSB + CW +: CW]),
        .value    (sec_val),
        .wrap     (sec_wrap)
      );
    end else begin : g_no_sec
      assign sec_val  = '0;
      assign sec_wrap = 1'b0;
    end
  endgenerate

  assign ev_wrap = pri_wrap | sec_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      of_q    <= 1'b0;
      syn_q   <= '0;
    end else begin
      if (err_valid)         valid_q <= 1'b1;
      else if (sw_clr_valid) valid_q <= 1'b0;

      if (act.set_of || ev_wrap) of_q <= 1'b1;
      else if (sw_clr_of)        of_q <= 1'b0;

      if (ev_capture) syn_q <= err_syndrome;
    end
  end

  logic [63:0] cnt_word;

  always_comb begin
    cnt_word = '0;
    cnt_word[CNT_LSB +: CWS]       = pri_val;
    cnt_word[CNT_LSB + CWS +: CWS] = sec_val;
    case (reg_addr)
      RA_FEAT: reg_rdata = FEAT;
      RA_STAT: reg_rdata = {62'd0, of_q, valid_q};
      RA_SYND: reg_rdata = 64'(syn_q);
      default: reg_rdata = cnt_word;
    endcase
  end

endmodule

// File: rtl/cer_record_chk.sv
module cer_record_chk #(
  parameter int SYN_W  = 32,
  parameter int POLICY = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic [SYN_W-1:0] err_syndrome,
  input logic [SYN_W-1:0] syn_q,
  input logic             valid_q,
  input logic             of_q,
  input logic             ev_wrap,
  input logic             sw_clr_of,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             wd0
);

  p_first_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !valid_q |=> valid_q && syn_q == $past(err_syndrome));

  p_keep_syn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 0) && err_valid && valid_q |=> $stable(syn_q));

  p_replace_syn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 1) && err_valid && valid_q && !of_q |=> syn_q == $past(err_syndrome));

  p_hold_after_of_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 1) && err_valid && valid_q && of_q |=> $stable(syn_q));

  p_wrap_sets_of_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> of_q);

  p_err_beats_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && reg_we && reg_addr == 2'd1 && wd0 |=> valid_q);

  p_of_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    of_q && !sw_clr_of |=> of_q);

endmodule

bind cer_record cer_record_chk #(.SYN_W(SYN_W), .POLICY(POLICY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_valid    (err_valid),
  .err_syndrome (err_syndrome),
  .syn_q        (syn_q),
  .valid_q      (valid_q),
  .of_q         (of_q),
  .ev_wrap      (ev_wrap),
  .sw_clr_of    (sw_clr_of),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .wd0          (reg_wdata[0])
);

// File: tb/sim_cer_record.sv
module sim_cer_record;

  localparam int CLK_P = 10;
  localparam int SW    = 8;
  localparam int CFG_W [3] = '{8, 16, 0};
  localparam int CFG_P [3] = '{1, 0, 0};
  localparam int CFG_R [3] = '{1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          ev [3];
  logic [SW-1:0] sy [3];
  logic [1:0]    ad [3];
  logic          we [3];
  logic [63:0]   wd [3];
  logic [63:0]   rd [3];

  int errors = 0;
  int checks = 0;

  logic [63:0] m_pri [3];
  logic [63:0] m_sec [3];
  logic [63:0] m_syn [3];
  logic        m_valid [3];
  logic        m_of [3];

  cer_record #(.SYN_W(SW), .CNT_SEL(1), .POLICY(1), .REPEAT_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .err_valid(ev[0]), .err_syndrome(sy[0]),
    .reg_addr(ad[0]), .reg_we(we[0]), .reg_wdata(wd[0]), .reg_rdata(rd[0]));
  cer_record #(.SYN_W(SW), .CNT_SEL(2), .POLICY(0), .REPEAT_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .err_valid(ev[1]), .err_syndrome(sy[1]),
    .reg_addr(ad[1]), .reg_we(we[1]), .reg_wdata(wd[1]), .reg_rdata(rd[1]));
  cer_record #(.SYN_W(SW), .CNT_SEL(0), .POLICY(0), .REPEAT_EN(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .err_valid(ev[2]), .err_syndrome(sy[2]),
    .reg_addr(ad[2]), .reg_we(we[2]), .reg_wdata(wd[2]), .reg_rdata(rd[2]));

  function automatic logic [63:0] mask_of(input int i);
    return (CFG_W[i] == 0) ? 64'd0 : ((64'd1 << CFG_W[i]) - 64'd1);
  endfunction

  task automatic check(input int i, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst u%0d: got %h expected %h", tag, i, got, exp);
    end
  endtask

  task automatic rd_reg(input int i, input logic [1:0] a, output logic [63:0] v);
    ad[i] = a;
    #1;
    v = rd[i];
  endtask

  // sel 0: counter at bit 32; sel 1: other counter above it.
  task automatic bump(input int i, input int sel);
    if (sel == 0) begin
      m_pri[i] = (m_pri[i] + 64'd1) & mask_of(i);
      if (m_pri[i] == 64'd0) m_of[i] = 1'b1;
    end else begin
      m_sec[i] = (m_sec[i] + 64'd1) & mask_of(i);
      if (m_sec[i] == 64'd0) m_of[i] = 1'b1;
    end
  endtask

  task automatic model_event(input int i, input logic [SW-1:0] s);
    logic of_before;
    of_before = m_of[i];
    if (!m_valid[i]) begin
      m_valid[i] = 1'b1;
      m_syn[i]   = 64'(s);
      if (CFG_W[i] > 0) bump(i, CFG_R[i]);
    end else begin
      if (CFG_W[i] > 0) bump(i, (CFG_R[i] == 1 && 64'(s) != m_syn[i]) ? 1 : 0);
      else if (CFG_P[i] == 0) m_of[i] = 1'b1;
      if (CFG_P[i] == 1 && !of_before) m_syn[i] = 64'(s);
    end
  endtask

  task automatic model_write(input int i, input logic [1:0] a, input logic [63:0] d);
    if (a == 2'd1) begin
      if (d[1]) m_of[i] = 1'b0;
      if (d[0]) m_valid[i] = 1'b0;
    end else if (a == 2'd3 && CFG_W[i] > 0) begin
      m_pri[i] = (d >> 32) & mask_of(i);
      if (CFG_R[i] == 1) m_sec[i] = (d >> (32 + CFG_W[i])) & mask_of(i);
    end
  endtask

  task automatic cmp_all(input int i, input string tag);
    logic [63:0] v;
    logic [63:0] exp_cnt;
    exp_cnt = (m_pri[i] << 32);
    if (CFG_R[i] == 1) exp_cnt = exp_cnt | (m_sec[i] << (32 + CFG_W[i]));
    rd_reg(i, 2'd1, v);
    check(i, tag, v, {62'd0, m_of[i], m_valid[i]});
    rd_reg(i, 2'd2, v);
    check(i, tag, v, m_syn[i]);
    rd_reg(i, 2'd3, v);
    check(i, tag, v, exp_cnt);
  endtask

  task automatic step(input int i, input logic e, input logic [SW-1:0] s, input logic w,
                      input logic [1:0] a, input logic [63:0] d, input string tag);
    @(negedge clk);
    ev[i] = e; sy[i] = s; we[i] = w; ad[i] = a; wd[i] = d;
    @(negedge clk);
    ev[i] = 1'b0; we[i] = 1'b0;
    if (e) model_event(i, s);
    else if (w) model_write(i, a, d);
    cmp_all(i, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] fexp;
    string tg;
    for (int i = 0; i < 3; i++) begin
      ev[i] = 1'b0; sy[i] = '0; ad[i] = 2'd0; we[i] = 1'b0; wd[i] = '0;
      m_pri[i] = '0; m_sec[i] = '0; m_syn[i] = '0; m_valid[i] = 1'b0; m_of[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 feature word
    for (int i = 0; i < 3; i++) begin
      cmp_all(i, "R1");
      fexp = 64'(CFG_W[i] == 8 ? 2 : (CFG_W[i] == 16 ? 4 : 0)) << 12;
      fexp = fexp | (64'(CFG_R[i]) << 15) | (64'(CFG_P[i]) << 18);
      rd_reg(i, 2'd0, v);
      check(i, "R2", v, fexp);
    end

    // R3 first capture into other counter (repeat mode)
    step(0, 1'b1, 8'd2, 1'b0, 2'd0, 64'd0, "R3");
    // R8 matching syndrome goes to repeat counter
    step(0, 1'b1, 8'd2, 1'b0, 2'd0, 64'd0, "R8");
    // R6 non-match replaces syndrome, counted in other counter
    step(0, 1'b1, 8'd1, 1'b0, 2'd0, 64'd0, "R6");
    // R10 preset 16-bit counter to all ones
    step(1, 1'b0, 8'd0, 1'b1, 2'd3, 64'h0000_FFFF_0000_0000, "R10");
    // R7 wrap sets overflow on the increment
    step(1, 1'b1, 8'd3, 1'b0, 2'd0, 64'd0, "R7");
    // R4 later error keeps syndrome
    step(1, 1'b1, 8'd1, 1'b0, 2'd0, 64'd0, "R4");
    // R11 write dropped when error same cycle
    step(1, 1'b1, 8'd2, 1'b1, 2'd1, 64'h3, "R11");
    // R9 write 0 no effect, write 1 clears overflow then valid
    step(1, 1'b0, 8'd0, 1'b1, 2'd1, 64'h0, "R9");
    step(1, 1'b0, 8'd0, 1'b1, 2'd1, 64'h2, "R9");
    step(1, 1'b0, 8'd0, 1'b1, 2'd1, 64'h1, "R9");
    // R5 no counter: second error sets overflow; R12 it stays
    step(2, 1'b1, 8'd1, 1'b0, 2'd0, 64'd0, "R5");
    step(2, 1'b1, 8'd2, 1'b0, 2'd0, 64'd0, "R5");
    step(2, 1'b1, 8'd3, 1'b0, 2'd0, 64'd0, "R12");

    // Sweeps with interleaved clears and presets
    for (int i = 0; i < 3; i++) begin
      logic [63:0] pre;
      tg = (i == 0) ? "R6 R8 R7" : ((i == 1) ? "R4 R7 R10" : "R5 R12");
      pre = (mask_of(i) - 64'd1) << 32;
      if (CFG_R[i] == 1) pre = pre | ((mask_of(i) - 64'd1) << (32 + CFG_W[i]));
      for (int k = 0; k < 300; k++) begin
        if (k % 60 == 59 && CFG_W[i] > 0) step(i, 1'b0, 8'd0, 1'b1, 2'd3, pre, tg);
        if (k % 37 == 36) step(i, 1'b0, 8'd0, 1'b1, 2'd1, 64'h2, tg);
        if (k % 53 == 52) step(i, 1'b0, 8'd0, 1'b1, 2'd1, 64'h1, tg);
        step(i, 1'b1, 8'((k * 3 + k / 5) % 4), (k % 41 == 40), 2'd1, 64'h3,
             (k % 41 == 40) ? "R11" : tg);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule